// File: doc/BRIEF.md
# PCIe Root Port Reset and Link Bring-Up Controller

This block sits beside one or more PCIe root ports and owns their reset sequencing. Software reaches it through a small register slave: one shared register turns on link training and L1 power management per port, and each port has its own reset register and a link-status register. Each reset register bit releases one active-low reset domain: PHY, PIPE, MAC, configuration space, or the endpoint PERST# line. Software brings a port up by writing zero to the register, then writing the auto-reset enables, then setting the release bits with a read-modify-write. After that it polls the link-status register and expects link-up within about 100 ms.

The link-up indication from each port's training state machine arrives asynchronously and passes through a synchronizer. When auto-reset is armed and the synchronized link falls from up to down, the block holds the MAC and configuration resets low for one cycle. The reset register keeps its value.

Address map: the shared register is at 0x0000. Port n occupies the window starting at (n+1)*0x1000. Inside that window the reset register is at offset 0x510 and the status register at offset 0x804. Every other address reads as zero and ignores writes.

Top module: `pcie_rst_ctl`

## Requirements
- R1: After reset, every reset output, ltssm_en and aspm_l1_en are 0, and every register reads 0.
- R2: In a port's reset register, bit 0 drives phy_rst_n, bit 1 pipe_rst_n, bit 2 mac_rst_n, bit 3 cfg_rst_n and bit 8 perst_n. Each output takes the new value at the clock edge that accepts the write. phy_rst_n, pipe_rst_n and perst_n change only on such a write.
- R3: The reset register stores and reads back bits 0-3, 8 and 13-15 (mask 0x0000E10F). All other bits read 0 whatever was written.
- R4: In the shared register, bit 8n drives ltssm_en[n] and bit 8n+1 drives aspm_l1_en[n]. All other bits read 0 (for 2 ports, writing all ones reads back 0x00000303).
- R5: Bit 10 of the status register reads 1 only when three things hold: the synchronized link-up of that port is 1, its ltssm_en is 1, and its MAC release bit (reset register bit 2) is 1. All other status bits read 0, and writes to the status register are ignored.
- R6: link_up_in passes through a two-flop synchronizer. A change applied between edges is visible to a status read sampled on the third edge, and not to one sampled on the second.
- R7: With reset register bits 15:13 all set, a fall of the synchronized link-up drives mac_rst_n and cfg_rst_n low for exactly one cycle, starting at the third clock edge after the input falls. phy_rst_n, pipe_rst_n, perst_n and the reset register value are unchanged.
- R8: If any of bits 15:13 is clear, a link fall leaves mac_rst_n and cfg_rst_n unchanged.
- R9: csr_rvalid is high in exactly the cycle after a read request, with csr_rdata valid. Unmapped addresses, including ports beyond NUM_PORTS, read 0 and ignore writes.
- R10: A link-down auto-reset on one port does not disturb the reset outputs of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | Register access request, one cycle per access |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 16 | Byte address of the register |
| csr_wdata | input | 32 | Write data |
| csr_rvalid | output | 1 | Read data valid, one cycle after a read request |
| csr_rdata | output | 32 | Read data |
| link_up_in | input | NUM_PORTS | Asynchronous link-up from each port's training logic |
| ltssm_en | output | NUM_PORTS | Link-training enable per port |
| aspm_l1_en | output | NUM_PORTS | L1 power-state enable per port |
| phy_rst_n | output | NUM_PORTS | PHY reset, active low |
| pipe_rst_n | output | NUM_PORTS | PIPE reset, active low |
| mac_rst_n | output | NUM_PORTS | MAC reset, active low |
| cfg_rst_n | output | NUM_PORTS | Configuration-space reset, active low |
| perst_n | output | NUM_PORTS | Endpoint PERST#, active low |

## Verification
The assertions rely on two properties of the register port:
- csr_req is 0 whenever no access is intended.
- Only the register path moves the PHY, PIPE and PERST# outputs.

The bench therefore drives csr_req and csr_we low from time zero, issues at most one access per cycle, and changes link_up_in only between clock edges. Read-valid timing and the one-cycle auto-reset window are checked under the same assumption that every access lasts exactly one cycle.

// File: rtl/pcie_rstctl_pkg.sv
package pcie_rstctl_pkg;

    // Register slave geometry
    localparam int unsigned CSR_AW  = 16;
    localparam int unsigned CSR_DW  = 32;
    localparam int unsigned OFS_W   = 12;
    localparam int unsigned WIN_W   = CSR_AW - OFS_W;

    // Offsets inside a window
    localparam logic [OFS_W-1:0] OFS_SHARED = 12'h000;
    localparam logic [OFS_W-1:0] OFS_RSTCTL = 12'h510;
    localparam logic [OFS_W-1:0] OFS_LSTAT  = 12'h804;

    // Reset register field positions
    localparam int unsigned B_PHY    = 0;
    localparam int unsigned B_PIPE   = 1;
    localparam int unsigned B_MAC    = 2;
    localparam int unsigned B_CFG    = 3;
    localparam int unsigned B_PERST  = 8;
    localparam int unsigned AUTO_LSB = 13;
    localparam int unsigned AUTO_W   = 3;

    // Status and shared register positions
    localparam int unsigned B_LINKUP    = 10;
    localparam int unsigned LANE_STRIDE = 8;
    localparam int unsigned B_TRAIN     = 0;
    localparam int unsigned B_L1        = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SHARED,
        SEL_RSTCTL,
        SEL_LSTAT
    } csr_sel_e;

    typedef struct packed {
        csr_sel_e         sel;
        logic [WIN_W-1:0] win;
    } csr_hit_t;

    typedef struct packed {
        logic phy;
        logic pipe;
        logic mac;
        logic cfg;
        logic perst;
    } dom_rst_t;

    function automatic logic [CSR_DW-1:0] rstctl_mask();
        logic [CSR_DW-1:0] m;
        m = '0;
        m[B_PHY]   = 1'b1;
        m[B_PIPE]  = 1'b1;
        m[B_MAC]   = 1'b1;
        m[B_CFG]   = 1'b1;
        m[B_PERST] = 1'b1;
        for (int i = 0; i < int'(AUTO_W); i++) m[AUTO_LSB + i] = 1'b1;
        return m;
    endfunction

    function automatic logic [CSR_DW-1:0] shared_mask(input int unsigned nports);
        logic [CSR_DW-1:0] m;
        m = '0;
        for (int p = 0; p < int'(nports); p++) begin
            m[p*LANE_STRIDE + B_TRAIN] = 1'b1;
            m[p*LANE_STRIDE + B_L1]    = 1'b1;
        end
        return m;
    endfunction

    function automatic csr_hit_t csr_decode(input logic [CSR_AW-1:0] addr,
                                            input int unsigned nports);
        csr_hit_t         h;
        logic [WIN_W-1:0] idx;
        logic [OFS_W-1:0] ofs;
        h.sel = SEL_NONE;
        h.win = '0;
        idx   = addr[CSR_AW-1:OFS_W];
        ofs   = addr[OFS_W-1:0];
        if (idx == '0) begin
            if (ofs == OFS_SHARED) h.sel = SEL_SHARED;
        end else if (int'(idx) <= int'(nports)) begin
            h.win = idx - 1'b1;
            if (ofs == OFS_RSTCTL)     h.sel = SEL_RSTCTL;
            else if (ofs == OFS_LSTAT) h.sel = SEL_LSTAT;
        end
        return h;
    endfunction

endpackage

// File: rtl/rstctl_link_sync.sv
module rstctl_link_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic link_raw,
    output logic link_s,
    output logic link_fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], link_raw};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign link_s    = chain_q[STAGES-1];
    assign link_fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rstctl_shared.sv
module rstctl_shared
    import pcie_rstctl_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CSR_DW-1:0]    wdata,
    output logic [NUM_PORTS-1:0] train_en,
    output logic [NUM_PORTS-1:0] l1_en,
    output logic [CSR_DW-1:0]    rd_val
);
    localparam logic [CSR_DW-1:0] MASK = shared_mask(NUM_PORTS);

    logic [CSR_DW-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= wdata & MASK;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        assign train_en[p] = cfg_q[p*LANE_STRIDE + B_TRAIN];
        assign l1_en[p]    = cfg_q[p*LANE_STRIDE + B_L1];
    end

    assign rd_val = cfg_q;
endmodule

// File: rtl/rstctl_port.sv
module rstctl_port
    import pcie_rstctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CSR_DW-1:0] wdata,
    input  logic              train_on,
    input  logic              link_s,
    input  logic              link_fall,
    output dom_rst_t          dom_n,
    output logic [CSR_DW-1:0] ctrl_rd,
    output logic              link_rpt,
    output logic              ld_pulse
);
    localparam logic [CSR_DW-1:0] MASK = rstctl_mask();

    logic [CSR_DW-1:0] ctrl_q;
    logic              hold_q;
    logic              auto_on;

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata & MASK;
    end

    assign auto_on  = &ctrl_q[AUTO_LSB +: AUTO_W];
    assign ld_pulse = link_fall & auto_on;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= ld_pulse;
    end

    always_comb begin
        dom_n.phy   = ctrl_q[B_PHY];
        dom_n.pipe  = ctrl_q[B_PIPE];
        dom_n.mac   = ctrl_q[B_MAC] & ~hold_q;
        dom_n.cfg   = ctrl_q[B_CFG] & ~hold_q;
        dom_n.perst = ctrl_q[B_PERST];
    end

    assign ctrl_rd  = ctrl_q;
    assign link_rpt = link_s & train_on & ctrl_q[B_MAC];
endmodule

// File: rtl/pcie_rst_ctl.sv
module pcie_rst_ctl
    import pcie_rstctl_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 csr_req,
    input  logic                 csr_we,
    input  logic [15:0]          csr_addr,
    input  logic [31:0]          csr_wdata,
    output logic                 csr_rvalid,
    output logic [31:0]          csr_rdata,
    input  logic [NUM_PORTS-1:0] link_up_in,
    output logic [NUM_PORTS-1:0] ltssm_en,
    output logic [NUM_PORTS-1:0] aspm_l1_en,
    output logic [NUM_PORTS-1:0] phy_rst_n,
    output logic [NUM_PORTS-1:0] pipe_rst_n,
    output logic [NUM_PORTS-1:0] mac_rst_n,
    output logic [NUM_PORTS-1:0] cfg_rst_n,
    output logic [NUM_PORTS-1:0] perst_n
);
    csr_hit_t            hit;
    logic                wr_cyc;
    logic                rd_cyc;
    logic [CSR_DW-1:0]   sh_rd;
    logic [CSR_DW-1:0]   ctl_rd [NUM_PORTS];
    logic [NUM_PORTS-1:0] link_rpt;
    logic [NUM_PORTS-1:0] ld_pulse;
    logic [CSR_DW-1:0]   rd_mux;
    logic [CSR_DW-1:0]   rdata_q;
    logic                rvalid_q;

    assign hit    = csr_decode(csr_addr, NUM_PORTS);
    assign wr_cyc = csr_req & csr_we;
    assign rd_cyc = csr_req & ~csr_we;

    rstctl_shared #(.NUM_PORTS(NUM_PORTS)) u_shared (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_cyc && hit.sel == SEL_SHARED),
        .wdata    (csr_wdata),
        .train_en (ltssm_en),
        .l1_en    (aspm_l1_en),
        .rd_val   (sh_rd)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic     ls;
        logic     lf;
        dom_rst_t dn;

        rstctl_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst       (rst),
            .link_raw  (link_up_in[p]),
            .link_s    (ls),
            .link_fall (lf)
        );

        rstctl_port u_port (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_cyc && hit.sel == SEL_RSTCTL && hit.win == WIN_W'(p)),
            .wdata     (csr_wdata),
            .train_on  (ltssm_en[p]),
            .link_s    (ls),
            .link_fall (lf),
            .dom_n     (dn),
            .ctrl_rd   (ctl_rd[p]),
            .link_rpt  (link_rpt[p]),
            .ld_pulse  (ld_pulse[p])
        );

        assign phy_rst_n[p]  = dn.phy;
        assign pipe_rst_n[p] = dn.pipe;
        assign mac_rst_n[p]  = dn.mac;
        assign cfg_rst_n[p]  = dn.cfg;
        assign perst_n[p]    = dn.perst;
    end

    always_comb begin
        rd_mux = '0;
        if (hit.sel == SEL_SHARED) rd_mux = sh_rd;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (hit.win == WIN_W'(p)) begin
                if (hit.sel == SEL_RSTCTL) rd_mux = ctl_rd[p];
                if (hit.sel == SEL_LSTAT)  rd_mux = CSR_DW'(link_rpt[p]) << B_LINKUP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_cyc;
            if (rd_cyc) rdata_q <= rd_mux;
        end
    end

    assign csr_rvalid = rvalid_q;
    assign csr_rdata  = rdata_q;
endmodule

// File: rtl/pcie_rst_ctl_chk.sv
module pcie_rst_ctl_chk #(
    parameter int unsigned NUM_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 csr_req,
    input logic                 csr_we,
    input logic                 csr_rvalid,
    input logic [NUM_PORTS-1:0] ltssm_en,
    input logic [NUM_PORTS-1:0] phy_rst_n,
    input logic [NUM_PORTS-1:0] pipe_rst_n,
    input logic [NUM_PORTS-1:0] mac_rst_n,
    input logic [NUM_PORTS-1:0] cfg_rst_n,
    input logic [NUM_PORTS-1:0] perst_n,
    input logic [NUM_PORTS-1:0] link_rpt,
    input logic [NUM_PORTS-1:0] ld_pulse
);
    // R9
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_req && !csr_we) |=> csr_rvalid);

    // R9
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(csr_req && !csr_we) |=> !csr_rvalid);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R2
        phy_by_write_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(phy_rst_n[p]) |-> $past(csr_req && csr_we));

        // R2
        pipe_by_write_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(pipe_rst_n[p]) |-> $past(csr_req && csr_we));

        // R2
        perst_by_write_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(perst_n[p]) |-> $past(csr_req && csr_we));

        // R7
        ld_clears_domains_chk: assert property (@(posedge clk) disable iff (rst)
            ld_pulse[p] |=> (!mac_rst_n[p] && !cfg_rst_n[p]));

        // R5
        link_needs_train_chk: assert property (@(posedge clk) disable iff (rst)
            link_rpt[p] |-> ltssm_en[p]);
    end
endmodule

bind pcie_rst_ctl pcie_rst_ctl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .csr_req    (csr_req),
    .csr_we     (csr_we),
    .csr_rvalid (csr_rvalid),
    .ltssm_en   (ltssm_en),
    .phy_rst_n  (phy_rst_n),
    .pipe_rst_n (pipe_rst_n),
    .mac_rst_n  (mac_rst_n),
    .cfg_rst_n  (cfg_rst_n),
    .perst_n    (perst_n),
    .link_rpt   (link_rpt),
    .ld_pulse   (ld_pulse)
);

// File: tb/sim_pcie_rst_ctl.sv
`timescale 1ns/1ps
module sim_pcie_rst_ctl;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csr_req = 1'b0;
    logic          csr_we = 1'b0;
    logic [15:0]   csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic          csr_rvalid;
    logic [31:0]   csr_rdata;
    logic [NP-1:0] link_up_in = '0;
    logic [NP-1:0] ltssm_en, aspm_l1_en, phy_rst_n, pipe_rst_n, mac_rst_n, cfg_rst_n, perst_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pcie_rst_ctl #(.NUM_PORTS(NP)) u0 (
        .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rvalid(csr_rvalid),
        .csr_rdata(csr_rdata), .link_up_in(link_up_in), .ltssm_en(ltssm_en),
        .aspm_l1_en(aspm_l1_en), .phy_rst_n(phy_rst_n), .pipe_rst_n(pipe_rst_n),
        .mac_rst_n(mac_rst_n), .cfg_rst_n(cfg_rst_n), .perst_n(perst_n)
    );

    function automatic logic [15:0] a_ctl(input int n);
        return 16'(((n + 1) << 12) | 'h510);
    endfunction
    function automatic logic [15:0] a_st(input int n);
        return 16'(((n + 1) << 12) | 'h804);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        csr_req = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_req = 0; csr_we = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        csr_req = 1; csr_we = 0; csr_addr = a;
        @(negedge clk);
        csr_req = 0;
        chk("R9 rvalid", 32'(csr_rvalid), 32'd1);
        d = csr_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] port_outs(input int n);
        return {27'd0, perst_n[n], cfg_rst_n[n], mac_rst_n[n], pipe_rst_n[n], phy_rst_n[n]};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 outputs", {phy_rst_n, pipe_rst_n, mac_rst_n, cfg_rst_n, perst_n, ltssm_en, aspm_l1_en}, 32'd0);
        rd(a_ctl(0), v); chk("R1 ctrl0", v, 0);
        rd(16'h0000, v); chk("R1 shared", v, 0);
        rd(a_st(1), v);  chk("R1 status1", v, 0);
    endtask

    task automatic t_ctrl_bits();
        wr(a_ctl(0), 32'h0000_0105);
        chk("R2 phy/mac/perst released", port_outs(0), 32'b10101);
        wr(a_ctl(0), 32'h0000_000A);
        chk("R2 pipe/cfg released", port_outs(0), 32'b01010);
        chk("R10 port1 untouched", port_outs(1), 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(a_ctl(0), 32'hFFFF_FFFF);
        rd(a_ctl(0), v); chk("R3 mask", v, 32'h0000_E10F);
        wr(a_ctl(0), 32'h0000_0000);
        rd(a_ctl(0), v); chk("R3 clear", v, 0);
    endtask

    task automatic t_shared();
        logic [31:0] v;
        wr(16'h0000, 32'h0000_0201);
        chk("R4 ltssm_en", 32'(ltssm_en), 32'b01);
        chk("R4 aspm_l1_en", 32'(aspm_l1_en), 32'b10);
        rd(16'h0000, v); chk("R4 readback", v, 32'h0000_0201);
        wr(16'h0000, 32'hFFFF_FFFF);
        rd(16'h0000, v); chk("R4 reserved", v, 32'h0000_0303);
    endtask

    task automatic t_link();
        logic [31:0] v;
        wr(16'h0000, 32'h0000_0101);
        wr(a_ctl(0), 32'h0000_010F);
        link_up_in[0] = 1'b1;
        rd(a_st(0), v); chk("R6 edge1", v, 0);
        rd(a_st(0), v); chk("R6 edge2", v, 0);
        rd(a_st(0), v); chk("R6 edge3", v, 32'h0000_0400);
        wr(a_st(0), 32'h0000_0000);
        rd(a_st(0), v); chk("R5 write ignored", v, 32'h0000_0400);
        wr(16'h0000, 32'h0000_0100);
        rd(a_st(0), v); chk("R5 ltssm gate", v, 0);
        wr(16'h0000, 32'h0000_0101);
        wr(a_ctl(0), 32'h0000_010B);
        rd(a_st(0), v); chk("R5 mac gate", v, 0);
        wr(a_ctl(0), 32'h0000_010F);
        rd(a_st(0), v); chk("R5 restored", v, 32'h0000_0400);
    endtask

    task automatic t_autoreset();
        logic [31:0] v;
        wr(a_ctl(0), 32'h0000_E10F);
        link_up_in[0] = 1'b0;
        cyc(2);
        chk("R7 before window", port_outs(0), 32'b11111);
        cyc(1);
        chk("R7 mac/cfg pulse", port_outs(0), 32'b10011);
        cyc(1);
        chk("R7 pulse ends", port_outs(0), 32'b11111);
        rd(a_ctl(0), v); chk("R7 register kept", v, 32'h0000_E10F);
    endtask

    task automatic t_noauto();
        link_up_in[0] = 1'b1;
        cyc(4);
        wr(a_ctl(0), 32'h0000_610F);
        link_up_in[0] = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 no pulse", port_outs(0), 32'b11111);
        end
    endtask

    task automatic t_indep();
        wr(a_ctl(0), 32'h0000_E10F);
        wr(a_ctl(1), 32'h0000_E10F);
        link_up_in = 2'b11;
        cyc(4);
        link_up_in[1] = 1'b0;
        cyc(3);
        chk("R10 port1 pulsed", port_outs(1), 32'b10011);
        chk("R10 port0 steady", port_outs(0), 32'b11111);
    endtask

    task automatic t_csr();
        logic [31:0] v;
        rd(16'h0100, v); chk("R9 unmapped read", v, 0);
        @(negedge clk);
        chk("R9 rvalid idle", 32'(csr_rvalid), 0);
        wr(16'h0510, 32'h0000_0000);
        wr(16'h3510, 32'h0000_0000);
        wr(16'h0804, 32'hFFFF_FFFF);
        rd(a_ctl(0), v); chk("R9 unmapped write port0", v, 32'h0000_E10F);
        rd(a_ctl(1), v); chk("R9 unmapped write port1", v, 32'h0000_E10F);
        rd(16'h3510, v); chk("R9 port beyond range", v, 0);
        rd(16'h0000, v); chk("R9 shared unchanged", v, 32'h0000_0101);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_bits();
        t_readback();
        t_shared();
        t_link();
        t_autoreset();
        t_noauto();
        t_indep();
        t_csr();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule